// File: doc/BRIEF.md
# Debug Control and Breakpoint Unit

This block holds the eight-bit debug control register of a small eight-bit processor. It decides whether the core runs freely, stalls its instruction fetch in debug mode, or spins on a software break opcode. Software or a debug host loads the register through a simple write port. The core raises a one-cycle pulse whenever it decodes the break opcode, which is 00H.

The unit handles that pulse according to the control bits. If breakpoints are disabled, the pulse has no effect and the opcode acts as a no-op. If breakpoints are enabled, the unit either enters debug mode or tells the core to keep looping on the break instruction. When acknowledge is enabled, a breakpoint also presents the byte FFH to the host byte transmitter. The unit holds that byte with a valid strobe until the transmitter signals ready, and then clears its own acknowledge-enable bit.

Writing a one to the lowest bit asks for a device reset. The unit answers with a single-cycle request pulse, and the other bits of the same write are kept. This gives the combined commands reset-and-stop (81H) and reset-and-go (41H).

Top module: `debug_break_ctl`

## Requirements
- R1: After reset the register reads 00H, and fetchStall, brkLoop, resetReq and ackValid are all 0.
- R2: A write stores bits 7 to 1 of wrData, and they read back on rdData from the next cycle. Bit 0 always reads back 0. Bits 3, 2 and 1 are plain storage.
- R3: fetchStall equals register bit 7 (debug mode). Writing 00H clears it so that fetching resumes.
- R4: When bit 6 (breakpoint enable) is 0, a brkHit pulse changes no register bit and raises neither brkLoop nor ackValid.
- R5: When bit 6 is 1 and bit 4 (loop) is 0, a brkHit pulse sets bit 7 in the following cycle.
- R6: When bits 6 and 4 are both 1, brkLoop is high in the same cycle as brkHit and bit 7 is left unchanged.
- R7: A breakpoint (brkHit with bit 6 set) while bit 5 (acknowledge enable) is 1 raises ackValid in the next cycle with ackByte = FFH. ackValid holds until ackReady is seen.
- R8: In the cycle when ackValid and ackReady are both high, the byte is accepted. From the next cycle ackValid is 0 and bit 5 reads 0.
- R9: A write with bit 0 set gives resetReq high for exactly the next cycle and keeps the other bits: 81H reads back 80H with fetchStall 1, and 41H reads back 40H with fetchStall 0.
- R10: If a write and a hardware update of the same bit fall in one cycle, the hardware update wins. This covers both the debug-mode set and the acknowledge-enable clear.
- R11: Writing 40H while in debug mode clears fetchStall and leaves breakpoints enabled (reads 40H).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register contents |
| brkHit | input | 1 | Pulse from the core: break opcode 00H decoded |
| brkLoop | output | 1 | Core must repeat the break instruction |
| fetchStall | output | 1 | Core must stop fetching new instructions |
| resetReq | output | 1 | One-cycle device reset request |
| ackReady | input | 1 | Host byte transmitter can accept a byte |
| ackValid | output | 1 | Acknowledge byte is offered |
| ackByte | output | 8 | Acknowledge byte, FFH |

## Verification
Two pairs of functions can land in the same clock edge. A software write can arrive together with a breakpoint that sets debug mode, and a software write can arrive together with the accepting handshake that clears the acknowledge enable. The bench provokes both by driving wrEn together with brkHit, and wrEn together with ackReady, using write data whose affected bit is the opposite of the hardware update. It judges the outcome from rdData and fetchStall one cycle later, where the hardware value must be the one that shows.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_DBG  = 7;
  localparam int BIT_EN   = 6;
  localparam int BIT_ACK  = 5;
  localparam int BIT_LOOP = 4;
  localparam int BIT_RST  = 0;
  localparam logic [REG_W-1:0] ACK_CODE = '1;
  localparam logic [REG_W-1:0] STORE_MASK = ~(REG_W'(1) << BIT_RST);

  typedef struct packed {
    logic load;
    logic setDbg;
    logic clrAck;
  } dbgStrobes_t;
endpackage

// File: rtl/dbgc_regfile.sv
module dbgc_regfile
  import dbgc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dbgStrobes_t      strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] ctrlQ
);
  logic [REG_W-1:0] nextQ;

  always_comb begin
    nextQ = ctrlQ;
    if (strb.load) nextQ = wrData & STORE_MASK;
    // hardware updates are applied after the write so they win
    if (strb.setDbg) nextQ[BIT_DBG] = 1'b1;
    if (strb.clrAck) nextQ[BIT_ACK] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else       ctrlQ <= nextQ;
  end
endmodule

// File: rtl/dbgc_sequencer.sv
module dbgc_sequencer
  import dbgc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrRst,
  input  logic             brkHit,
  input  logic             ackReady,
  input  logic [REG_W-1:0] ctrlQ,
  output dbgStrobes_t      strb,
  output logic             brkLoop,
  output logic             resetReq,
  output logic             ackValid,
  output logic [REG_W-1:0] ackByte
);
  logic brkTaken;
  logic ackFire;
  logic ackPending;

  assign brkTaken = brkHit & ctrlQ[BIT_EN];
  assign ackFire  = ackPending & ackReady;

  always_comb begin
    strb.load   = wrEn;
    strb.setDbg = brkTaken & ~ctrlQ[BIT_LOOP];
    strb.clrAck = ackFire;
  end

  assign brkLoop  = brkTaken & ctrlQ[BIT_LOOP];
  assign ackValid = ackPending;
  assign ackByte  = ACK_CODE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPending <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      resetReq <= wrEn & wrRst;
      if (ackFire)
        ackPending <= 1'b0;
      else if (brkTaken & ctrlQ[BIT_ACK])
        ackPending <= 1'b1;
    end
  end
endmodule

// File: rtl/debug_break_ctl.sv
module debug_break_ctl
  import dbgc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             brkHit,
  output logic             brkLoop,
  output logic             fetchStall,
  output logic             resetReq,
  input  logic             ackReady,
  output logic             ackValid,
  output logic [REG_W-1:0] ackByte
);
  dbgStrobes_t      strb;
  logic [REG_W-1:0] ctrlQ;

  dbgc_regfile i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .ctrlQ(ctrlQ)
  );

  dbgc_sequencer i_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrRst(wrData[BIT_RST]),
    .brkHit(brkHit), .ackReady(ackReady), .ctrlQ(ctrlQ), .strb(strb),
    .brkLoop(brkLoop), .resetReq(resetReq), .ackValid(ackValid),
    .ackByte(ackByte)
  );

  assign rdData     = ctrlQ;
  assign fetchStall = ctrlQ[BIT_DBG];
endmodule

// File: rtl/dbgc_checker.sv
module dbgc_checker
  import dbgc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [REG_W-1:0] rdData,
  input logic             brkHit,
  input logic             brkLoop,
  input logic             fetchStall,
  input logic             resetReq,
  input logic             ackReady,
  input logic             ackValid,
  input logic [REG_W-1:0] ackByte
);
  assert_brk_halts_R5: assert property (@(posedge clk) disable iff (!rstN)
    (brkHit && rdData[BIT_EN] && !rdData[BIT_LOOP]) |=> fetchStall);

  assert_loop_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (brkHit && rdData[BIT_EN] && rdData[BIT_LOOP] && !wrEn) |=> $stable(fetchStall));

  assert_brk_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (brkHit && !rdData[BIT_EN] && !wrEn && !(ackValid && ackReady)) |=> $stable(rdData));

  assert_ack_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && !ackReady) |=> ackValid);

  assert_ack_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> ackByte == ACK_CODE);

  assert_ack_selfclear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackReady) |=> (!ackValid && !rdData[BIT_ACK]));

  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[BIT_RST]) |=> resetReq);

  assert_rst_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrData[BIT_RST]) |=> !resetReq);
endmodule

bind debug_break_ctl dbgc_checker i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .brkHit(brkHit), .brkLoop(brkLoop), .fetchStall(fetchStall),
  .resetReq(resetReq), .ackReady(ackReady), .ackValid(ackValid),
  .ackByte(ackByte)
);

// File: tb/test_debug_break_ctl.sv
module test_debug_break_ctl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       brkHit = 1'b0;
  logic       brkLoop;
  logic       fetchStall;
  logic       resetReq;
  logic       ackReady = 1'b0;
  logic       ackValid;
  logic [7:0] ackByte;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  debug_break_ctl i_debug_break_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .brkHit(brkHit), .brkLoop(brkLoop), .fetchStall(fetchStall),
    .resetReq(resetReq), .ackReady(ackReady), .ackValid(ackValid),
    .ackByte(ackByte)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    @(negedge clk);
    wrEn = 1'b0; wrData = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 outputs", {4'h0, fetchStall, brkLoop, resetReq, ackValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R9: sweep every write value
    for (int v = 0; v < 256; v++) begin
      writeReg(8'(v));
      chk("R2 readback", rdData, 8'(v) & 8'hFE);
      chk("R3 fetchStall", {7'h0, fetchStall}, {7'h0, v[7]});
      chk("R9 resetReq pulse", {7'h0, resetReq}, {7'h0, v[0]});
      @(negedge clk);
      chk("R9 pulse single", {7'h0, resetReq}, 8'h00);
    end
    writeReg(8'h00);
    chk("R3 resume", {7'h0, fetchStall}, 8'h00);

    // R4 R5 R6 R7 R8: sweep enable, loop and acknowledge configurations
    for (int c = 0; c < 8; c++) begin
      logic en, lp, ak;
      en = c[0]; lp = c[1]; ak = c[2];
      writeReg({1'b0, en, ak, lp, 4'h0});
      brkHit = 1'b1;
      #1;
      chk("R6 brkLoop same cycle", {7'h0, brkLoop}, {7'h0, en & lp});
      @(negedge clk);
      brkHit = 1'b0;
      chk(en ? "R5 debug set" : "R4 no effect", {7'h0, fetchStall}, {7'h0, en & ~lp});
      chk("R7 ackValid", {7'h0, ackValid}, {7'h0, en & ak});
      if (!en) chk("R4 register unchanged", rdData, {2'b00, ak, lp, 4'h0});
      if (ackValid) begin
        chk("R7 ackByte", ackByte, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R7 hold without ready", {7'h0, ackValid}, 8'h01);
        ackReady = 1'b1;
        @(negedge clk);
        ackReady = 1'b0;
        chk("R8 valid dropped", {7'h0, ackValid}, 8'h00);
        chk("R8 enable cleared", {7'h0, rdData[5]}, 8'h00);
      end else begin
        chk("R7 enable kept", {7'h0, rdData[5]}, {7'h0, ak});
      end
      writeReg(8'h00);
    end

    // R10: hardware debug set beats a write of bit 7 = 0
    writeReg(8'h40);
    wrEn = 1'b1; wrData = 8'h40; brkHit = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; brkHit = 1'b0;
    chk("R10 debug set wins", rdData, 8'hC0);
    // R11: 40H while in debug resumes
    writeReg(8'h40);
    chk("R11 readback", rdData, 8'h40);
    chk("R11 fetch resumes", {7'h0, fetchStall}, 8'h00);

    // R10: acknowledge clear beats a write of bit 5 = 1
    writeReg(8'h70);
    brkHit = 1'b1;
    @(negedge clk);
    brkHit = 1'b0;
    chk("R7 ack in loop", {7'h0, ackValid}, 8'h01);
    wrEn = 1'b1; wrData = 8'h60; ackReady = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; ackReady = 1'b0;
    chk("R10 ack clear wins", rdData, 8'h40);
    chk("R8 valid gone", {7'h0, ackValid}, 8'h00);

    // R9: reset-and-stop and reset-and-go
    writeReg(8'h81);
    chk("R9 81H readback", rdData, 8'h80);
    chk("R9 81H stall", {7'h0, fetchStall}, 8'h01);
    chk("R9 81H pulse", {7'h0, resetReq}, 8'h01);
    writeReg(8'h41);
    chk("R9 41H readback", rdData, 8'h40);
    chk("R9 41H run", {7'h0, fetchStall}, 8'h00);
    chk("R9 41H pulse", {7'h0, resetReq}, 8'h01);
    @(negedge clk);
    chk("R9 pulse ends", {7'h0, resetReq}, 8'h00);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule